// File: doc/BRIEF.md
# Single-Wire Bus Master Timing Engine

This block is the timing engine of a master for a single-line, open-drain serial bus that carries both data and power to its slaves. A host hands it one command at a time over a valid/ready handshake. The command can be a bus reset, a one-bit write or a one-bit read. The engine pulls the line low and releases it with microsecond-accurate timing, then returns one response. For a reset the response holds the presence flag and a line-short flag. For a write or read it holds the bit.

All timing counts microsecond ticks, which are derived from the system clock by a restartable prescaler. Each command carries a speed-select bit that chooses the standard or the fast timing set. Each command also carries two configuration values, both in microseconds. The first is a slot length, which excludes recovery. The second is a recovery interval, applied after every slot and after the presence window. During recovery the line is released so that parasitically powered slaves can recharge. The host can therefore lower the data rate in exchange for more charging time on a heavily loaded line.

The controller has six states:
- `ST_IDLE`: ready to accept a command.
- `ST_RST_LOW`: the reset pulse.
- `ST_RST_HIGH`: the presence window.
- `ST_SLOT_LOW`: the low part of a bit slot.
- `ST_SLOT_HIGH`: the released remainder of a bit slot.
- `ST_RECOVER`: the recovery interval.

The transitions are:
- Accept: from idle to reset-low when the opcode is 00, otherwise to slot-low.
- Reset release: from reset-low to reset-high after the reset low time.
- Window end: from reset-high to recover after the same duration again, with the response issued.
- Low end: from slot-low to slot-high after the low time. If the slot length has already been reached, the engine goes straight to recover and issues the response.
- Slot end: from slot-high to recover when the slot length is reached, with the response issued.
- Recovery done: from recover to idle after the recovery interval.

Top module: `swm_master`

## Requirements
- R1: The reset pulse pulls the line low for 480 µs at standard speed and 48 µs at fast speed (`cmd_op` = 2'b00).
- R2: After a reset, the line is released for a window as long as the reset pulse. `rsp_bit` is returned as 1 (slave present) when the synchronised line is low 70 µs after release at standard speed, or 8 µs after release at fast speed.
- R3: `rsp_short` is 1 when the synchronised line never reads high during the reset window. It is 0 for every write and read response.
- R4: A write (`cmd_op` = 2'b01) pulls the line low for 6 µs when `cmd_bit` is 1 and 60 µs when it is 0 at standard speed. At fast speed the values are 1 µs and 6 µs. `rsp_bit` echoes `cmd_bit`.
- R5: A read (`cmd_op` = 2'b10 or 2'b11) pulls the line low for 6 µs (standard) or 1 µs (fast). It then returns in `rsp_bit` the synchronised line level sampled 15 µs (standard) or 2 µs (fast) after the falling edge.
- R6: A slot lasts the larger of `cfg_slot_us`, the slot's low time, and (for reads only) the sample time. `rsp_valid` pulses for one cycle at the end of the slot, or at the end of the reset window, with the line released.
- R7: After each response the line stays released and `cmd_ready` stays low for `cfg_rec_us` µs plus one clock. `cmd_ready` is low for the whole command.
- R8: The line is pulled low only from the accepting clock edge to the end of the command's low phase. It is never pulled low at any other time.
- R9: After reset, `cmd_ready` is 1, `line_pull_low` is 0 and `rsp_valid` is 0.
- R10: Speed, slot length and recovery are sampled when the command is accepted, so that consecutive commands may use different timing sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle and able to accept a command |
| cmd_op | input | 2 | 00 reset, 01 write, 1x read |
| cmd_bit | input | 1 | Bit to write |
| cmd_overdrive | input | 1 | 1 selects the fast timing set |
| cfg_slot_us | input | CFG_W | Slot length in µs, excluding recovery |
| cfg_rec_us | input | CFG_W | Recovery interval in µs |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_bit | output | 1 | Presence flag (reset) or data bit |
| rsp_short | output | 1 | Line held low through the reset window |
| line_pull_low | output | 1 | Open-drain enable; 1 pulls the line low |
| line_in | input | 1 | Raw line level |

## Verification
The accepting edge is taken as cycle zero, and every result is due on a cycle that can be counted from it in units of C, the clocks per microsecond.
- `line_pull_low` reads high on exactly the first L·C sampled cycles, where L is the low time.
- `rsp_valid` is seen on cycle P·C alone, where P is the slot or window length.
- `cmd_ready` returns on cycle (P + recovery)·C + 1.

The bench samples on the falling clock edge with a cycle counter that starts at the accept. It compares each event's cycle index against these bench-computed numbers, so an early or late response counts as a failure just as a wrong value does. The slave model's pull-down windows are placed several microseconds around each sample point. This keeps the two-stage input synchroniser out of the expected results.

// File: rtl/swm_pkg.sv
package swm_pkg;

    localparam int US_W = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_HIGH,
        ST_SLOT_LOW,
        ST_SLOT_HIGH,
        ST_RECOVER
    } swm_state_e;

    typedef struct packed {
        logic [US_W-1:0] rst_len;
        logic [US_W-1:0] pres_smp;
        logic [US_W-1:0] low_len;
        logic [US_W-1:0] rd_smp;
        logic [US_W-1:0] slot_len;
    } swm_times_t;

endpackage

// File: rtl/swm_tick.sv
module swm_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    generate
        if (CLK_PER_US <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CNT_W = $clog2(CLK_PER_US);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_PER_US - 1);
            logic [CNT_W-1:0] presc;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              presc <= '0;
                else if (restart)        presc <= '0;
                else if (presc == LAST)  presc <= '0;
                else                     presc <= presc + 1'b1;
            end

            assign tick = (presc == LAST);

            // R1: ticks are spaced so microsecond phases cannot collapse
            assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/swm_sync.sv
module swm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/swm_timing.sv
module swm_timing
    import swm_pkg::*;
#(
    parameter int CFG_W        = 8,
    parameter int STD_RST_US   = 480,
    parameter int STD_PRES_US  = 70,
    parameter int STD_LOW1_US  = 6,
    parameter int STD_LOW0_US  = 60,
    parameter int STD_SMP_US   = 15,
    parameter int OD_RST_US    = 48,
    parameter int OD_PRES_US   = 8,
    parameter int OD_LOW1_US   = 1,
    parameter int OD_LOW0_US   = 6,
    parameter int OD_SMP_US    = 2
) (
    input  logic             fast,
    input  logic             is_read,
    input  logic             wr_bit,
    input  logic [CFG_W-1:0] cfg_slot,
    output swm_times_t       times
);
    logic [US_W-1:0] low_v;
    logic [US_W-1:0] smp_v;
    logic [US_W-1:0] floor_v;
    logic [US_W-1:0] cfg_v;

    always_comb begin
        times.rst_len  = fast ? US_W'(OD_RST_US)  : US_W'(STD_RST_US);
        times.pres_smp = fast ? US_W'(OD_PRES_US) : US_W'(STD_PRES_US);
        smp_v          = fast ? US_W'(OD_SMP_US)  : US_W'(STD_SMP_US);
        if (is_read || wr_bit) low_v = fast ? US_W'(OD_LOW1_US) : US_W'(STD_LOW1_US);
        else                   low_v = fast ? US_W'(OD_LOW0_US) : US_W'(STD_LOW0_US);
        floor_v        = (is_read && smp_v > low_v) ? smp_v : low_v;
        cfg_v          = US_W'(cfg_slot);
        times.low_len  = low_v;
        times.rd_smp   = smp_v;
        times.slot_len = (cfg_v > floor_v) ? cfg_v : floor_v;
    end
endmodule

// File: rtl/swm_master.sv
module swm_master
    import swm_pkg::*;
#(
    parameter int CLK_PER_US  = 50,
    parameter int CFG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_bit,
    input  logic             cmd_overdrive,
    input  logic [CFG_W-1:0] cfg_slot_us,
    input  logic [CFG_W-1:0] cfg_rec_us,
    output logic             rsp_valid,
    output logic             rsp_bit,
    output logic             rsp_short,
    output logic             line_pull_low,
    input  logic             line_in
);
    swm_state_e       state, state_d;
    logic [US_W-1:0]  us_cnt, cnt_d, cnt_inc;
    logic             is_rst_q, is_rd_q, bit_q, fast_q;
    logic             is_rst_d, is_rd_d, bit_d, fast_d;
    logic [CFG_W-1:0] slot_q, rec_q, slot_d, rec_d;
    logic             samp_q, samp_d, seen_hi_q, seen_hi_d;
    logic             rsp_valid_d, rsp_bit_d, rsp_short_d;
    logic             smp_now;
    logic             tick, line_s, accept;
    swm_times_t       tm;

    assign accept  = (state == ST_IDLE) && cmd_valid;
    assign cnt_inc = us_cnt + 1'b1;

    swm_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(accept), .tick(tick));

    swm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(line_in), .q_out(line_s));

    swm_timing #(.CFG_W(CFG_W)) u_timing (
        .fast(fast_q), .is_read(is_rd_q), .wr_bit(bit_q),
        .cfg_slot(slot_q), .times(tm));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            us_cnt    <= '0;
            is_rst_q  <= 1'b0;
            is_rd_q   <= 1'b0;
            bit_q     <= 1'b0;
            fast_q    <= 1'b0;
            slot_q    <= '0;
            rec_q     <= '0;
            samp_q    <= 1'b0;
            seen_hi_q <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_bit   <= 1'b0;
            rsp_short <= 1'b0;
        end else begin
            state     <= state_d;
            us_cnt    <= cnt_d;
            is_rst_q  <= is_rst_d;
            is_rd_q   <= is_rd_d;
            bit_q     <= bit_d;
            fast_q    <= fast_d;
            slot_q    <= slot_d;
            rec_q     <= rec_d;
            samp_q    <= samp_d;
            seen_hi_q <= seen_hi_d;
            rsp_valid <= rsp_valid_d;
            rsp_bit   <= rsp_bit_d;
            rsp_short <= rsp_short_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d     = state;
        cnt_d       = us_cnt;
        is_rst_d    = is_rst_q;
        is_rd_d     = is_rd_q;
        bit_d       = bit_q;
        fast_d      = fast_q;
        slot_d      = slot_q;
        rec_d       = rec_q;
        samp_d      = samp_q;
        seen_hi_d   = seen_hi_q;
        rsp_valid_d = 1'b0;
        rsp_bit_d   = rsp_bit;
        rsp_short_d = rsp_short;
        smp_now     = samp_q;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    is_rst_d  = (cmd_op == 2'b00);
                    is_rd_d   = cmd_op[1];
                    bit_d     = cmd_bit;
                    fast_d    = cmd_overdrive;
                    slot_d    = cfg_slot_us;
                    rec_d     = cfg_rec_us;
                    samp_d    = 1'b0;
                    seen_hi_d = 1'b0;
                    cnt_d     = '0;
                    state_d   = (cmd_op == 2'b00) ? ST_RST_LOW : ST_SLOT_LOW;
                end
            end
            ST_RST_LOW: begin
                if (tick) begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == tm.rst_len) begin
                        cnt_d   = '0;
                        state_d = ST_RST_HIGH;
                    end
                end
            end
            ST_RST_HIGH: begin
                if (line_s) seen_hi_d = 1'b1;
                if (tick) begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == tm.pres_smp) smp_now = ~line_s;
                    samp_d = smp_now;
                    if (cnt_inc == tm.rst_len) begin
                        cnt_d       = '0;
                        state_d     = ST_RECOVER;
                        rsp_valid_d = 1'b1;
                        rsp_bit_d   = smp_now;
                        rsp_short_d = ~(seen_hi_q | line_s);
                    end
                end
            end
            ST_SLOT_LOW: begin
                if (tick) begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == tm.low_len) begin
                        if (cnt_inc >= tm.slot_len) begin
                            cnt_d       = '0;
                            state_d     = ST_RECOVER;
                            rsp_valid_d = 1'b1;
                            rsp_bit_d   = is_rd_q ? samp_q : bit_q;
                            rsp_short_d = 1'b0;
                        end else begin
                            state_d = ST_SLOT_HIGH;
                        end
                    end
                end
            end
            ST_SLOT_HIGH: begin
                if (tick) begin
                    cnt_d = cnt_inc;
                    if (is_rd_q && cnt_inc == tm.rd_smp) smp_now = line_s;
                    samp_d = smp_now;
                    if (cnt_inc >= tm.slot_len) begin
                        cnt_d       = '0;
                        state_d     = ST_RECOVER;
                        rsp_valid_d = 1'b1;
                        rsp_bit_d   = is_rd_q ? smp_now : bit_q;
                        rsp_short_d = 1'b0;
                    end
                end
            end
            ST_RECOVER: begin
                if (us_cnt >= US_W'(rec_q)) state_d = ST_IDLE;
                else if (tick)              cnt_d   = cnt_inc;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready     = (state == ST_IDLE);
        line_pull_low = (state == ST_RST_LOW) || (state == ST_SLOT_LOW);
    end

    // R6: response is a single-cycle strobe
    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6: line is released whenever a response is presented
    assert_rsp_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !line_pull_low);

    // R7: host cannot issue the next command while a response is fresh
    assert_ready_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);

    // R8: line only starts being pulled low by an accepted command
    assert_pull_from_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_pull_low) |-> $past(cmd_valid && cmd_ready));

    // R3: short flag only appears on reset responses
    assert_short_reset_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_short) |-> is_rst_q);
endmodule

// File: tb/swm_master_test.sv
module swm_master_test;
    localparam int C     = 4;
    localparam int CFG_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [1:0]       cmd_op = 2'b00;
    logic             cmd_bit = 1'b0;
    logic             cmd_overdrive = 1'b0;
    logic [CFG_W-1:0] cfg_slot_us = '0;
    logic [CFG_W-1:0] cfg_rec_us = '0;
    logic             rsp_valid, rsp_bit, rsp_short, line_pull_low;
    logic             slave_low = 1'b0;
    wire              line_in = !line_pull_low && !slave_low;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    swm_master #(.CLK_PER_US(C), .CFG_W(CFG_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_bit(cmd_bit), .cmd_overdrive(cmd_overdrive),
        .cfg_slot_us(cfg_slot_us), .cfg_rec_us(cfg_rec_us),
        .rsp_valid(rsp_valid), .rsp_bit(rsp_bit), .rsp_short(rsp_short),
        .line_pull_low(line_pull_low), .line_in(line_in));

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int low_us(input logic [1:0] op, input bit b, input bit od);
        if (op == 2'b00) return od ? 48 : 480;             // R1
        if (op[1] || b)  return od ? 1 : 6;                // R4 R5
        return od ? 6 : 60;                                 // R4
    endfunction

    function automatic int active_us(input logic [1:0] op, input bit b, input bit od, input int slot);
        int f;
        if (op == 2'b00) return 2 * low_us(op, b, od);      // R2
        f = low_us(op, b, od);
        if (op[1] && (od ? 2 : 15) > f) f = od ? 2 : 15;   // R6
        return (slot > f) ? slot : f;
    endfunction

    task automatic run_cmd(input logic [1:0] op, input bit b, input bit od, input int slot,
                           input int rec, input bit present, input bit short_ln, input bit rbit);
        int L, P, k, low_bad, rsp_n, rsp_k, got_bit, got_short, exp_bit;
        L = low_us(op, b, od) * C;
        P = active_us(op, b, od, slot) * C;
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_bit = b; cmd_overdrive = od;
        cfg_slot_us = CFG_W'(slot); cfg_rec_us = CFG_W'(rec);
        cmd_valid = 1'b1;
        slave_low = short_ln;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = ~op; cmd_bit = ~b; cmd_overdrive = ~od;   // R10: changes after accept ignored
        cfg_slot_us = 8'd3; cfg_rec_us = 8'd200;
        low_bad = 0; rsp_n = 0; rsp_k = -1; got_bit = 0; got_short = 0; k = 0;
        while (!cmd_ready && k < 20000) begin
            if (line_pull_low != (k < L)) low_bad++;
            if (rsp_valid) begin
                rsp_n++; rsp_k = k; got_bit = rsp_bit; got_short = rsp_short;
            end
            if (!short_ln) begin
                if (op == 2'b00)
                    slave_low = present && (k >= L + (od ? 3 : 30) * C) && (k < L + (od ? 12 : 100) * C);
                else if (op[1])
                    slave_low = !rbit && (k < (od ? 5 : 30) * C);
                else
                    slave_low = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        slave_low = 1'b0;
        exp_bit = (op == 2'b00) ? (present || short_ln) : (op[1] ? rbit : b);
        chk(low_bad == 0, (op == 2'b00) ? "R1 R8 reset low span" : "R4 R5 R8 slot low span", low_bad, 0);
        chk(rsp_n == 1 && rsp_k == P, "R6 R10 response cycle", rsp_k, P);
        chk(got_bit == exp_bit, (op == 2'b00) ? "R2 presence" : (op[1] ? "R5 read bit" : "R4 write echo"),
            got_bit, exp_bit);
        chk(got_short == int'(short_ln && op == 2'b00), "R3 short flag", got_short, int'(short_ln));
        chk(k == P + rec * C + 1, "R7 ready return cycle", k, P + rec * C + 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int sd;
        sd = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(cmd_ready == 1'b1, "R9 ready after reset", cmd_ready, 1);
        chk(line_pull_low == 1'b0, "R9 line released after reset", line_pull_low, 0);
        chk(rsp_valid == 1'b0, "R9 no response after reset", rsp_valid, 0);

        // directed corners
        run_cmd(2'b00, 0, 0, 0, 5, 1, 0, 0);    // R1 R2 standard reset with presence
        run_cmd(2'b00, 0, 0, 0, 0, 0, 0, 0);    // R2 no presence, zero recovery
        run_cmd(2'b00, 0, 1, 0, 2, 0, 1, 0);    // R3 shorted line, fast
        run_cmd(2'b00, 0, 1, 0, 1, 1, 0, 0);    // R10 fast reset with presence
        run_cmd(2'b01, 1, 0, 70, 3, 0, 0, 0);   // R4 write one
        run_cmd(2'b01, 0, 0, 10, 3, 0, 0, 0);   // R6 slot shorter than write-zero low
        run_cmd(2'b10, 0, 0, 65, 255, 0, 0, 0); // R5 R7 read zero, long recovery
        run_cmd(2'b11, 0, 0, 0, 0, 0, 0, 1);    // R5 R6 read one, slot floor at sample
        run_cmd(2'b01, 0, 1, 8, 1, 0, 0, 0);    // R4 fast write zero
        run_cmd(2'b10, 0, 1, 0, 1, 0, 0, 1);    // R5 fast read one
        run_cmd(2'b10, 0, 1, 10, 0, 0, 0, 0);   // R5 fast read zero

        // random mix
        for (int i = 0; i < 24; i++) begin
            logic [1:0] op;
            op = 2'($urandom % 4);
            run_cmd(op, 1'($urandom % 2), 1'($urandom % 2), int'($urandom % 90),
                    int'($urandom % 40), 1'($urandom % 2), 1'b0, 1'($urandom % 2));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule